// File: doc/BRIEF.md
# Mailbox Receiver Register Frame

This block is the receiving side of an inter-processor mailbox. A sending agent raises bits in per-window 32-bit status words through a dedicated set port. Software on the receiving processor reaches the status words through a simple word-wide register bus. It can read each window either raw or through its mask, lower bits with write-1-to-clear, and set or clear individual mask bits through two separate write-only registers.

A window needs attention when its masked status is nonzero. All windows are summarised one bit per window in four combined-status words. Together with a frame-level enable, these drive a single interrupt line. A multi-word message can keep every window but its last fully masked, so the receiver is interrupted only once the final word has arrived.

Every status-clear write is reported back to the sender on a one-cycle clear-pulse port. The pulse carries the window index and the bits actually lowered, so the sender can tell that a message was consumed.

Top module: `mbox_rx_frame`

## Requirements
- R1: After reset, every status word is 0, every mask word is all ones, the combined-interrupt enable is 0, `irq` is low and `bus_rdata` is 0.
- R2: Window w occupies byte addresses w*0x20 to w*0x20+0x1F. The registers in a window sit at these offsets: raw status +0x00, masked status +0x04, status clear +0x08, mask +0x10, mask set +0x14, mask clear +0x18. Only windows below `NUM_WIN` respond.
- R3: A cycle with `snd_set_valid` high ORs `snd_set_bits` into the status word of window `snd_set_win`. An index at or above `NUM_WIN` changes nothing.
- R4: Writing the status-clear register lowers each status bit written as 1 and leaves the others. Writing all ones empties the word.
- R5: Writing mask set raises the written mask bits, and writing mask clear lowers them. Neither changes the status word. The mask register reads back the current mask.
- R6: Masked status reads as status AND NOT mask.
- R7: The four combined-status words at 0xFA0, 0xFA4, 0xFA8 and 0xFAC hold one bit per window. Window w sits at word w/32, bit w%32, and the bit is 1 when that window's masked status is nonzero. Bits for absent windows read 0.
- R8: The configuration word at 0xF80 reads `NUM_WIN` in bits [6:0] and 0 in all other bits.
- R9: The enable word at 0xF98 stores bit 2 as the combined-interrupt enable; its other bits read 0. `irq` is high exactly when that enable is 1 and at least one combined-status bit is 1.
- R10: When a sender set and a status-clear write hit the same bit in the same cycle, the bit ends up 1.
- R11: A status-clear write is followed, in the next cycle only, by `clr_pulse_valid` high. In that cycle `clr_pulse_win` holds the window index and `clr_pulse_bits` holds the bits the write actually lowered.
- R12: A read returns its data on `bus_rdata` one clock after the access and holds it until the next read. Unmapped addresses, write-only registers and absent windows read 0. Writes to read-only registers change nothing.
- R13: `irq` falls in the cycle after the last masked status bit disappears, whether that bit was cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| snd_set_valid | input | 1 | Sender set strobe |
| snd_set_win | input | 7 | Window addressed by the sender |
| snd_set_bits | input | 32 | Bits to raise in that window |
| clr_pulse_valid | output | 1 | One-cycle notice of a status-clear write |
| clr_pulse_win | output | 7 | Window that was cleared |
| clr_pulse_bits | output | 32 | Bits actually lowered |
| irq | output | 1 | Combined receive interrupt |

## Verification
A corrupted status or mask bit shows up one clock later in three places: the masked-status read of that window, its combined-status bit, and `irq` once the enable is set. Raw reads then tell whether the status or the mask was wrong. A lost sender set under a concurrent clear shows up in the same cycle as an all-zero `clr_pulse_bits`, and in the following read as a missing raw bit. A decode error shows up as data that lands in the wrong window or offset, which the next read of the intended register exposes.

// File: rtl/mbox_rx_pkg.sv
// Shared constants and types of the mailbox receiver frame.
// Assumes a 12-bit byte address space and 32-bit words.
package mbox_rx_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int WIN_IDX_W = 7;
    localparam int COMB_REGS = 4;
    localparam int IEN_BIT   = 2;

    // Word offsets (addr[4:2]) inside one window
    localparam logic [2:0] OFF_RAW    = 3'd0;
    localparam logic [2:0] OFF_MASKED = 3'd1;
    localparam logic [2:0] OFF_CLR    = 3'd2;
    localparam logic [2:0] OFF_MASK   = 3'd4;
    localparam logic [2:0] OFF_MSET   = 3'd5;
    localparam logic [2:0] OFF_MCLR   = 3'd6;

    // Frame-level registers
    localparam logic [ADDR_W-1:0] FRAME_BASE = 12'hF80;
    localparam logic [ADDR_W-1:0] ADDR_CFG   = 12'hF80;
    localparam logic [ADDR_W-1:0] ADDR_IEN   = 12'hF98;
    localparam logic [ADDR_W-1:0] ADDR_COMB  = 12'hFA0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_WIN,
        SEL_CFG,
        SEL_IEN,
        SEL_COMB
    } sel_e;
endpackage

// File: rtl/mbox_rx_decode.sv
// Address decoder: classifies a bus access and produces the write strobes.
// Assumes windows fill the space below FRAME_BASE at a 32-byte stride.
module mbox_rx_decode
    import mbox_rx_pkg::*;
#(
    parameter int NUM_WIN = 36
) (
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output sel_e                 sel_o,
    output logic [WIN_IDX_W-1:0] win_idx_o,
    output logic [2:0]           off_o,
    output logic [1:0]           comb_idx_o,
    output logic                 clr_hit_o,
    output logic                 mset_hit_o,
    output logic                 mclr_hit_o,
    output logic                 ien_wr_o
);
    logic in_frame;
    logic win_ok;
    logic wr;

    assign win_idx_o  = bus_addr[ADDR_W-1:5];
    assign off_o      = bus_addr[4:2];
    assign comb_idx_o = bus_addr[3:2];
    assign in_frame   = bus_addr >= FRAME_BASE;
    assign win_ok     = !in_frame && (int'(win_idx_o) < NUM_WIN);
    assign wr         = bus_en && bus_we;

    // Pick the register group the address falls into
    always_comb begin
        if (win_ok)                                          sel_o = SEL_WIN;
        else if (bus_addr[ADDR_W-1:2] == ADDR_CFG[ADDR_W-1:2]) sel_o = SEL_CFG;
        else if (bus_addr[ADDR_W-1:2] == ADDR_IEN[ADDR_W-1:2]) sel_o = SEL_IEN;
        else if (bus_addr[ADDR_W-1:4] == ADDR_COMB[ADDR_W-1:4]) sel_o = SEL_COMB;
        else                                                 sel_o = SEL_NONE;
    end

    assign clr_hit_o  = wr && (sel_o == SEL_WIN) && (off_o == OFF_CLR);
    assign mset_hit_o = wr && (sel_o == SEL_WIN) && (off_o == OFF_MSET);
    assign mclr_hit_o = wr && (sel_o == SEL_WIN) && (off_o == OFF_MCLR);
    assign ien_wr_o   = wr && (sel_o == SEL_IEN);
endmodule

// File: rtl/mbox_rx_window.sv
// One mailbox window: status word with set/clear, mask word with set/clear.
// Assumes a set and a clear may coincide; the set takes priority.
module mbox_rx_window
    import mbox_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_i,
    input  logic [WORD_W-1:0] clr_i,
    input  logic [WORD_W-1:0] mset_i,
    input  logic [WORD_W-1:0] mclr_i,
    output logic [WORD_W-1:0] stat_o,
    output logic [WORD_W-1:0] mask_o,
    output logic              active_o
);
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] mask_q;

    // Status and mask storage; set beats clear on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= (stat_q & ~clr_i) | set_i;
            mask_q <= (mask_q | mset_i) & ~mclr_i;
        end
    end

    assign stat_o   = stat_q;
    assign mask_o   = mask_q;
    assign active_o = |(stat_q & ~mask_q);

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i) != '0) |=> ((stat_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

    // R4
    clear_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mset_i != '0) |=> ((mask_q & $past(mset_i)) == $past(mset_i)));

    // R5
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr_i != '0) |=> ((mask_q & $past(mclr_i)) == '0));
endmodule

// File: rtl/mbox_rx_frame.sv
// Mailbox receiver frame: windows, combined status, interrupt, read mux
// and clear-pulse feedback. Assumes NUM_WIN between 1 and 124.
module mbox_rx_frame
    import mbox_rx_pkg::*;
#(
    parameter int NUM_WIN = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 snd_set_valid,
    input  logic [WIN_IDX_W-1:0] snd_set_win,
    input  logic [WORD_W-1:0]    snd_set_bits,
    output logic                 clr_pulse_valid,
    output logic [WIN_IDX_W-1:0] clr_pulse_win,
    output logic [WORD_W-1:0]    clr_pulse_bits,
    output logic                 irq
);
    localparam int COMB_W   = COMB_REGS * WORD_W;
    localparam int COMB_PAD = COMB_W - NUM_WIN;

    sel_e                 sel;
    logic [WIN_IDX_W-1:0] win_idx;
    logic [2:0]           off;
    logic [1:0]           comb_idx;
    logic                 clr_hit, mset_hit, mclr_hit, ien_wr;

    logic [WORD_W-1:0] w_set  [NUM_WIN];
    logic [WORD_W-1:0] w_clr  [NUM_WIN];
    logic [WORD_W-1:0] w_mset [NUM_WIN];
    logic [WORD_W-1:0] w_mclr [NUM_WIN];
    logic [WORD_W-1:0] w_stat [NUM_WIN];
    logic [WORD_W-1:0] w_mask [NUM_WIN];
    logic [NUM_WIN-1:0] act;
    logic [COMB_W-1:0]  comb_vec;

    logic [WORD_W-1:0] sel_stat, sel_mask, sel_set, rd_next;
    logic              ien_q;

    mbox_rx_decode #(.NUM_WIN(NUM_WIN)) u_dec (
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .sel_o      (sel),
        .win_idx_o  (win_idx),
        .off_o      (off),
        .comb_idx_o (comb_idx),
        .clr_hit_o  (clr_hit),
        .mset_hit_o (mset_hit),
        .mclr_hit_o (mclr_hit),
        .ien_wr_o   (ien_wr)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [WIN_IDX_W-1:0] IDX = WIN_IDX_W'(w);
        assign w_set[w]  = (snd_set_valid && snd_set_win == IDX) ? snd_set_bits : '0;
        assign w_clr[w]  = (clr_hit  && win_idx == IDX) ? bus_wdata : '0;
        assign w_mset[w] = (mset_hit && win_idx == IDX) ? bus_wdata : '0;
        assign w_mclr[w] = (mclr_hit && win_idx == IDX) ? bus_wdata : '0;

        mbox_rx_window u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (w_set[w]),
            .clr_i    (w_clr[w]),
            .mset_i   (w_mset[w]),
            .mclr_i   (w_mclr[w]),
            .stat_o   (w_stat[w]),
            .mask_o   (w_mask[w]),
            .active_o (act[w])
        );
    end

    if (COMB_PAD > 0) begin : g_pad
        assign comb_vec = {{COMB_PAD{1'b0}}, act};
    end else begin : g_nopad
        assign comb_vec = act;
    end

    // Select the addressed window's words for reads and clear feedback
    always_comb begin
        sel_stat = '0;
        sel_mask = '0;
        sel_set  = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_idx == WIN_IDX_W'(w)) begin
                sel_stat = w_stat[w];
                sel_mask = w_mask[w];
                sel_set  = w_set[w];
            end
        end
    end

    // Read data multiplexer over all register groups
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_WIN: begin
                if (off == OFF_RAW)         rd_next = sel_stat;
                else if (off == OFF_MASKED) rd_next = sel_stat & ~sel_mask;
                else if (off == OFF_MASK)   rd_next = sel_mask;
            end
            SEL_CFG:  rd_next = WORD_W'(WIN_IDX_W'(NUM_WIN));
            SEL_IEN:  rd_next = WORD_W'(ien_q) << IEN_BIT;
            SEL_COMB: rd_next = comb_vec[comb_idx*WORD_W +: WORD_W];
            default:  rd_next = '0;
        endcase
    end

    // Registered read data, updated only on read accesses
    always_ff @(posedge clk) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_next;
    end

    // Combined-interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (ien_wr) ien_q <= bus_wdata[IEN_BIT];
    end

    // One-cycle clear notice carrying the bits actually lowered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_pulse_valid <= 1'b0;
            clr_pulse_win   <= '0;
            clr_pulse_bits  <= '0;
        end else begin
            clr_pulse_valid <= clr_hit;
            if (clr_hit) begin
                clr_pulse_win  <= win_idx;
                clr_pulse_bits <= bus_wdata & sel_stat & ~sel_set;
            end
        end
    end

    assign irq = ien_q && (|act);

    // R9
    irq_off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !bus_wdata[IEN_BIT]) |=> !irq);

    // R11
    clr_pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> clr_pulse_valid);

    // R11
    clr_pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse_valid |-> ($past(clr_hit) && ((clr_pulse_bits & ~$past(bus_wdata)) == '0)));
endmodule

// File: tb/mbox_rx_frame_tb.sv
// Directed bench for the mailbox receiver frame.
module mbox_rx_frame_tb;
    localparam int NW = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        snd_set_valid = 1'b0;
    logic [6:0]  snd_set_win = '0;
    logic [31:0] snd_set_bits = '0;
    logic        clr_pulse_valid;
    logic [6:0]  clr_pulse_win;
    logic [31:0] clr_pulse_bits;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mbox_rx_frame #(.NUM_WIN(NW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snd_set_valid(snd_set_valid), .snd_set_win(snd_set_win),
        .snd_set_bits(snd_set_bits),
        .clr_pulse_valid(clr_pulse_valid), .clr_pulse_win(clr_pulse_win),
        .clr_pulse_bits(clr_pulse_bits), .irq(irq)
    );

    function automatic logic [11:0] wa(input int win, input int off);
        return 12'(win * 32 + off);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic snd(input int win, input logic [31:0] bits);
        @(negedge clk);
        snd_set_valid = 1'b1; snd_set_win = 7'(win); snd_set_bits = bits;
        @(negedge clk);
        snd_set_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(wa(0, 'h00), d); check("R1 raw", d, 32'h0);
        rd(wa(7, 'h10), d); check("R1 mask", d, 32'hFFFF_FFFF);
        rd(12'hF98, d);     check("R1 enable", d, 32'h0);
        rd(12'hF80, d);     check("R8 config", d, 32'(NW));
    endtask

    task automatic t_set_views();
        logic [31:0] d;
        snd(3, 32'h0000_00A5);
        rd(wa(3, 'h00), d); check("R3 R2 raw", d, 32'h0000_00A5);
        rd(wa(3, 'h04), d); check("R6 masked all", d, 32'h0);
        rd(wa(2, 'h00), d); check("R2 neighbour", d, 32'h0);
        rd(12'hFA0, d);     check("R7 comb masked", d, 32'h0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        wr(wa(3, 'h18), 32'h0000_000F);
        rd(wa(3, 'h10), d); check("R5 mask clr", d, 32'hFFFF_FFF0);
        rd(wa(3, 'h04), d); check("R6 masked", d, 32'h0000_0005);
        rd(12'hFA0, d);     check("R7 comb0", d, 32'h0000_0008);
        check("R9 irq disabled", {31'b0, irq}, 32'h0);
        wr(12'hF98, 32'hFFFF_FFFF);
        rd(12'hF98, d);     check("R9 enable read", d, 32'h0000_0004);
        check("R9 irq on", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = wa(3, 'h08); bus_wdata = 32'h0000_0004;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R11 pulse valid", {31'b0, clr_pulse_valid}, 32'h1);
        check("R11 pulse win", {25'b0, clr_pulse_win}, 32'd3);
        check("R11 pulse bits", clr_pulse_bits, 32'h0000_0004);
        @(negedge clk);
        check("R11 pulse one cycle", {31'b0, clr_pulse_valid}, 32'h0);
        rd(wa(3, 'h00), d); check("R4 partial", d, 32'h0000_00A1);
        check("R9 irq still", {31'b0, irq}, 32'h1);
        wr(wa(3, 'h08), 32'hFFFF_FFFF);
        check("R13 irq drop clear", {31'b0, irq}, 32'h0);
        rd(wa(3, 'h00), d); check("R4 all ones", d, 32'h0);
        rd(12'hFA0, d);     check("R7 comb cleared", d, 32'h0);
    endtask

    task automatic t_mask_deassert();
        logic [31:0] d;
        wr(wa(35, 'h18), 32'hFFFF_FFFF);
        snd(35, 32'h0000_0002);
        rd(12'hFA4, d); check("R7 comb1", d, 32'h0000_0008);
        check("R9 irq w35", {31'b0, irq}, 32'h1);
        wr(wa(35, 'h14), 32'h0000_0002);
        check("R13 irq drop mask", {31'b0, irq}, 32'h0);
        rd(wa(35, 'h10), d); check("R5 mask set", d, 32'h0000_0002);
        rd(wa(35, 'h00), d); check("R5 status kept", d, 32'h0000_0002);
        rd(12'hFA8, d);      check("R7 comb absent", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = wa(5, 'h08); bus_wdata = 32'h0000_0001;
        snd_set_valid = 1'b1; snd_set_win = 7'd5; snd_set_bits = 32'h0000_0001;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; snd_set_valid = 1'b0;
        check("R10 pulse lowered none", clr_pulse_bits, 32'h0);
        rd(wa(5, 'h00), d); check("R10 set wins", d, 32'h0000_0001);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'hF84, d);     check("R12 unmapped", d, 32'h0);
        rd(wa(40, 'h00), d); check("R12 absent window", d, 32'h0);
        rd(wa(5, 'h14), d); check("R12 write-only reads 0", d, 32'h0);
        wr(wa(0, 'h00), 32'h0000_FFFF);
        rd(wa(0, 'h00), d); check("R12 raw read-only", d, 32'h0);
        snd(50, 32'hFFFF_FFFF);
        rd(wa(0, 'h00), d); check("R3 bad index w0", d, 32'h0);
        rd(wa(5, 'h00), d); check("R3 bad index w5", d, 32'h0000_0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_views();
        t_mask_irq();
        t_clear();
        t_mask_deassert();
        t_set_wins();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule